// File: doc/BRIEF.md
# Packed Decimal Digit Shift with Rounding

This unit moves the magnitude of a signed packed-decimal number left or right by a whole number of decimal digits in one clocked step. The 128-bit operand carries 31 magnitude digits, four bits each, above a sign code in the lowest nibble. A signed 8-bit count selects the direction and distance. Right shifts round half-up on the most significant digit that falls off, with the increment carried decimally through the kept digits. The output carries the canonical sign code for the operand's sign, together with a condition nibble that compares the result with zero and flags lost digits or a malformed operand.

The interface is a single-cycle pipeline stage with no back-pressure. A request is presented by raising `in_valid` for one cycle with the operand, count and sign-style select. The unit accepts a new request in every cycle. Exactly one cycle later `out_done` pulses for one cycle, and `out_result` / `out_cond` hold that answer until the next accepted request. The consumer must take the result while `out_done` is high, or before it issues another request.

Top module: `dsr_unit`

## Requirements
- R1: While reset is active, and after it is released with no request, `out_done` is 0, `out_result` is all zeros and `out_cond` is 4'b0000.
- R2: `out_done` is high in exactly the cycle after each cycle with `in_valid` high. `out_result` and `out_cond` change only on such cycles and otherwise hold their value.
- R3: A positive count n moves the magnitude digits up by n digit places, fills the vacated low digits with 0, and writes the canonical sign into nibble 0.
- R4: On a left shift, if any nonzero digit is pushed beyond digit 31, the overflow bit `out_cond[0]` is set. A right shift or a zero count never sets it for a valid operand.
- R5: A negative count -n moves the magnitude digits down by n places and discards the low digits. When the most significant discarded digit is 0 to 4, the kept digits are returned unchanged.
- R6: When the most significant discarded digit is 5 to 9, one is added to the kept magnitude with decimal carry between digits (for example, 1999 becomes 2000).
- R7: The count is a two's-complement byte clamped to the range -31 to +31, so 8'h80 acts as -31 and 8'h7F acts as +31.
- R8: The output sign code is 4'hD for a negative operand (sign 4'hB or 4'hD). For a positive operand (4'hA, 4'hC, 4'hE, 4'hF) it is 4'hC when `in_sign_sel` is 0 and 4'hF when it is 1.
- R9: `out_cond` is {LT, GT, EQ, OV} from bit 3 down to bit 0. EQ is set when all 31 result digits are zero, regardless of sign. Otherwise LT is set for a negative sign and GT for a positive one. OV is ORed in.
- R10: An operand with any magnitude digit above 9, or a sign nibble below 4'hA, yields `out_cond` = 4'b0001 and `out_result` all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe, one cycle per request |
| in_operand | input | 128 | Packed-decimal operand, sign in bits 3:0 |
| in_count | input | 8 | Signed digit shift count |
| in_sign_sel | input | 1 | Positive sign style: 0 gives 4'hC, 1 gives 4'hF |
| out_done | output | 1 | One-cycle pulse, result available |
| out_result | output | 128 | Shifted, rounded, re-signed value |
| out_cond | output | 4 | {LT, GT, EQ, OV} condition |

## Verification
The properties assume that every request is a single-cycle `in_valid` pulse whose operand, count and select are stable at the capturing edge. They do not assume the operand is well formed, because malformed operands must land on the 4'b0001 condition. The sign and no-overflow properties therefore accept that invalid outcome as an alternative. The stimulus drives all inputs at the falling edge, holds each request for exactly one cycle, and deliberately includes malformed digits, malformed signs and out-of-range counts, so those alternatives are exercised and not merely tolerated.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam logic [3:0] SGN_NEG_PREF = 4'hD;
  localparam logic [3:0] SGN_POS_PREF = 4'hC;
  localparam logic [3:0] SGN_POS_ALT  = 4'hF;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_GT = 2'd1,
    CMP_LT = 2'd2
  } cmp_e;

  function automatic logic sign_is_neg(input logic [3:0] s);
    return (s == 4'hB) || (s == 4'hD);
  endfunction

  function automatic logic sign_is_legal(input logic [3:0] s);
    return s >= 4'hA;
  endfunction

  function automatic logic [3:0] cond_encode(input cmp_e c, input logic ov);
    logic [3:0] r;
    r = 4'b0000;
    case (c)
      CMP_LT:  r[3] = 1'b1;
      CMP_GT:  r[2] = 1'b1;
      default: r[1] = 1'b1;
    endcase
    r[0] = ov;
    return r;
  endfunction
endpackage

// File: rtl/dsr_validate.sv
module dsr_validate #(
  parameter int DIGITS = 31,
  localparam int W = (DIGITS + 1) * 4
) (
  input  logic [W-1:0] operand,
  output logic         legal,
  output logic         neg
);
  logic [DIGITS-1:0] dig_ok;

  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    assign dig_ok[d] = operand[(d+1)*4 +: 4] <= 4'd9;
  end

  assign legal = (&dig_ok) && dsr_pkg::sign_is_legal(operand[3:0]);
  assign neg   = dsr_pkg::sign_is_neg(operand[3:0]);
endmodule

// File: rtl/dsr_shift.sv
module dsr_shift #(
  parameter int DIGITS = 31,
  parameter int CW = 8,
  localparam int W = (DIGITS + 1) * 4
) (
  input  logic [W-1:0]  mag,
  input  logic [CW-1:0] count,
  output logic [W-1:0]  shifted,
  output logic          went_right,
  output logic          lost_digits
);
  localparam logic signed [CW-1:0] MAXC = CW'(DIGITS);

  logic signed [CW-1:0] cnt_s;
  logic [CW-1:0]        amt;
  logic                 go_left;
  logic [CW+1:0]        bits;
  logic [2*W-1:0]       wide_l;
  logic [W-1:0]         right_v;

  assign cnt_s = count;

  always_comb begin
    if (cnt_s > MAXC) begin
      go_left = 1'b1;
      amt     = MAXC;
    end else if (cnt_s < -MAXC) begin
      go_left = 1'b0;
      amt     = MAXC;
    end else if (cnt_s >= 0) begin
      go_left = 1'b1;
      amt     = cnt_s;
    end else begin
      go_left = 1'b0;
      amt     = CW'(-cnt_s);
    end
  end

  assign bits    = {amt, 2'b00};
  assign wide_l  = {{W{1'b0}}, mag} << bits;
  assign right_v = mag >> bits;

  assign shifted     = go_left ? wide_l[W-1:0] : right_v;
  assign went_right  = ~go_left;
  assign lost_digits = go_left & (|wide_l[2*W-1:W]);
endmodule

// File: rtl/dsr_round.sv
module dsr_round #(
  parameter int DIGITS = 31,
  localparam int W = (DIGITS + 1) * 4
) (
  input  logic [W-1:0]      vec,
  input  logic              allow,
  output logic [W-5:0]      digits_out
);
  logic [DIGITS:0] carry;

  assign carry[0] = allow && (vec[3:0] >= 4'd5);

  for (genvar d = 0; d < DIGITS; d++) begin : g_inc
    logic [3:0] dig_in;
    logic [4:0] sum;
    assign dig_in = vec[(d+1)*4 +: 4];
    assign sum    = {1'b0, dig_in} + {4'b0000, carry[d]};
    always_comb begin
      if (sum > 5'd9) begin
        digits_out[d*4 +: 4] = 4'd0;
        carry[d+1]           = 1'b1;
      end else begin
        digits_out[d*4 +: 4] = sum[3:0];
        carry[d+1]           = 1'b0;
      end
    end
  end
endmodule

// File: rtl/dsr_unit.sv
module dsr_unit #(
  parameter int DIGITS = 31,
  parameter int CW = 8,
  localparam int W = (DIGITS + 1) * 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_operand,
  input  logic [CW-1:0] in_count,
  input  logic          in_sign_sel,
  output logic          out_done,
  output logic [W-1:0]  out_result,
  output logic [3:0]    out_cond
);
  import dsr_pkg::*;

  logic         op_legal, op_neg;
  logic [W-1:0] mag;
  logic [W-1:0] sh_v;
  logic         sh_right, sh_lost;
  logic [W-5:0] rnd_digits;
  logic [3:0]   new_sign;
  logic [W-1:0] nxt_result;
  logic [3:0]   nxt_cond;
  cmp_e         cmp;

  dsr_validate #(.DIGITS(DIGITS)) u_val (
    .operand (in_operand),
    .legal   (op_legal),
    .neg     (op_neg)
  );

  assign mag = {in_operand[W-1:4], 4'h0};

  dsr_shift #(.DIGITS(DIGITS), .CW(CW)) u_sh (
    .mag         (mag),
    .count       (in_count),
    .shifted     (sh_v),
    .went_right  (sh_right),
    .lost_digits (sh_lost)
  );

  dsr_round #(.DIGITS(DIGITS)) u_rnd (
    .vec        (sh_v),
    .allow      (sh_right),
    .digits_out (rnd_digits)
  );

  always_comb begin
    if (op_neg)           new_sign = SGN_NEG_PREF;
    else if (in_sign_sel) new_sign = SGN_POS_ALT;
    else                  new_sign = SGN_POS_PREF;

    if (rnd_digits == '0) cmp = CMP_EQ;
    else if (op_neg)      cmp = CMP_LT;
    else                  cmp = CMP_GT;

    if (op_legal) begin
      nxt_result = {rnd_digits, new_sign};
      nxt_cond   = cond_encode(cmp, sh_lost);
    end else begin
      nxt_result = '0;
      nxt_cond   = 4'b0001;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_done   <= 1'b0;
      out_result <= '0;
      out_cond   <= 4'b0000;
    end else begin
      out_done <= in_valid;
      if (in_valid) begin
        out_result <= nxt_result;
        out_cond   <= nxt_cond;
      end
    end
  end
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
  parameter int W = 128,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [W-1:0]  in_operand,
  input logic [CW-1:0] in_count,
  input logic          in_sign_sel,
  input logic          out_done,
  input logic [W-1:0]  out_result,
  input logic [3:0]    out_cond
);
  // R2: done follows a request by one cycle
  p_done_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_done);
  // R2: no request, no done, outputs hold
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_done && $stable(out_result) && $stable(out_cond)));
  // R4: right shift or zero count never reports overflow unless the operand is malformed
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $signed(in_count) <= 0) |=> (!out_cond[0] || out_cond == 4'b0001));
  // R8: negative operands come out with sign D
  p_neg_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_operand[3:0] == 4'hB || in_operand[3:0] == 4'hD))
      |=> (out_result[3:0] == 4'hD || out_cond == 4'b0001));
  // R8: positive operand with alternate select gives sign F
  p_alt_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sign_sel && in_operand[3:0] == 4'hC)
      |=> (out_result[3:0] == 4'hF || out_cond == 4'b0001));
  // R9: at most one comparison flag
  p_cmp_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> $onehot0(out_cond[3:1]));
  // R9: EQ only with a zero magnitude
  p_eq_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && out_cond[1]) |-> (out_result[W-1:4] == '0));
  // R9: a zero operand with zero count reports EQ
  p_zero_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_count == '0 && in_operand[W-1:4] == '0 && in_operand[3:0] >= 4'hA)
      |=> (out_cond == 4'b0010));
  // R10: malformed sign nibble reports only the invalid flag
  p_bad_sign_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_operand[3:0] < 4'hA) |=> (out_cond == 4'b0001 && out_result == '0));
endmodule

bind dsr_unit dsr_checker #(.W(W), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_operand  (in_operand),
  .in_count    (in_count),
  .in_sign_sel (in_sign_sel),
  .out_done    (out_done),
  .out_result  (out_result),
  .out_cond    (out_cond)
);

// File: tb/sim_dsr_unit.sv
module sim_dsr_unit;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 14;

  typedef struct packed {
    logic [127:0] op;
    logic [7:0]   cnt;
    logic         sel;
    logic [127:0] res;
    logic [3:0]   cond;
    logic [7:0]   req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    // R3: left by 2, sign C kept
    '{128'h12_3C, 8'h02, 1'b0, 128'h12_300C, 4'b0100, 8'd3},
    // R8: negative, left by 1
    '{128'h123D, 8'h01, 1'b1, 128'h1230D, 4'b1000, 8'd8},
    // R5: right by 2, dropped 4, no round
    '{128'h12343C, 8'hFE, 1'b0, 128'h123C, 4'b0100, 8'd5},
    // R6: right by 2, dropped 5, round up
    '{128'h12351F, 8'hFE, 1'b1, 128'h124F, 4'b0100, 8'd6},
    // R6: decimal carry 1999 -> 2000
    '{128'h19996A, 8'hFF, 1'b0, 128'h2000C, 4'b0100, 8'd6},
    // R4: top digit pushed out
    '{128'h1000_0000_0000_0000_0000_0000_0000_000C, 8'h01, 1'b0, 128'hC, 4'b0011, 8'd4},
    // R4: digit 30 reaches digit 31, no overflow
    '{128'h0100_0000_0000_0000_0000_0000_0000_000D, 8'h01, 1'b0,
      128'h1000_0000_0000_0000_0000_0000_0000_000D, 4'b1000, 8'd4},
    // R7: count -128 clamps to -31, dropped 7 rounds up
    '{128'h7000_0000_0000_0000_0000_0000_0000_000C, 8'h80, 1'b0, 128'h1C, 4'b0100, 8'd7},
    // R9: zero magnitude with negative sign is EQ
    '{128'h0D, 8'h00, 1'b0, 128'h0D, 4'b0010, 8'd9},
    // R10: digit A is malformed
    '{128'hA5C, 8'h00, 1'b0, 128'h0, 4'b0001, 8'd10},
    // R10: sign 3 is malformed
    '{128'h123, 8'h03, 1'b0, 128'h0, 4'b0001, 8'd10},
    // R8: sign E with select 1 -> F
    '{128'h7E, 8'h00, 1'b1, 128'h7F, 4'b0100, 8'd8},
    // R8: sign B -> D
    '{128'h7B, 8'h00, 1'b0, 128'h7D, 4'b1000, 8'd8},
    // R5: right by 31 clears all digits
    '{128'h4C, 8'hE1, 1'b0, 128'hC, 4'b0010, 8'd5}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] in_operand = '0;
  logic [7:0]   in_count = '0;
  logic         in_sign_sel = 1'b0;
  logic         out_done;
  logic [127:0] out_result;
  logic [3:0]   out_cond;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsr_unit u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_operand  (in_operand),
    .in_count    (in_count),
    .in_sign_sel (in_sign_sel),
    .out_done    (out_done),
    .out_result  (out_result),
    .out_cond    (out_cond)
  );

  task automatic check(input string tag, input logic [127:0] ares, input logic [3:0] acond,
                       input logic adone, input logic [127:0] eres, input logic [3:0] econd,
                       input logic edone);
    n_checks++;
    if (ares !== eres || acond !== econd || adone !== edone) begin
      n_fail++;
      $display("FAIL %s: got res=%h cond=%b done=%b, expected res=%h cond=%b done=%b",
               tag, ares, acond, adone, eres, econd, edone);
    end
  endtask

  task automatic request(input logic [127:0] op, input logic [7:0] cnt, input logic sel);
    @(negedge clk);
    in_operand  = op;
    in_count    = cnt;
    in_sign_sel = sel;
    in_valid    = 1'b1;
    @(negedge clk);
    in_valid    = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state under reset
    check("R1 in reset", out_result, out_cond, out_done, 128'h0, 4'b0000, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after reset", out_result, out_cond, out_done, 128'h0, 4'b0000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      request(VEC[i].op, VEC[i].cnt, VEC[i].sel);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), out_result, out_cond, out_done,
            VEC[i].res, VEC[i].cond, 1'b1);
    end

    // R2: done lasts one cycle, outputs hold while idle inputs change
    request(128'h55C, 8'h01, 1'b0);
    check("R2 result", out_result, out_cond, out_done, 128'h550C, 4'b0100, 1'b1);
    in_operand = 128'h99D;
    in_count   = 8'hFF;
    @(negedge clk);
    check("R2 pulse ends", out_result, out_cond, out_done, 128'h550C, 4'b0100, 1'b0);
    @(negedge clk);
    check("R2 hold", out_result, out_cond, out_done, 128'h550C, 4'b0100, 1'b0);

    // R7: +127 clamps to +31, every digit leaves the top
    request(128'h1C, 8'h7F, 1'b1);
    check("R7 left clamp", out_result, out_cond, out_done, 128'hF, 4'b0011, 1'b1);

    // R2: back-to-back requests each produce a result
    @(negedge clk);
    in_valid = 1'b1; in_operand = 128'h21C; in_count = 8'h00; in_sign_sel = 1'b0;
    @(negedge clk);
    check("R2 back-to-back a", out_result, out_cond, out_done, 128'h21C, 4'b0100, 1'b1);
    in_operand = 128'h21D;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 back-to-back b", out_result, out_cond, out_done, 128'h21D, 4'b1000, 1'b1);

    // R1: reset mid-stream clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset", out_result, out_cond, out_done, 128'h0, 4'b0000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got running, expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule